// File: doc/BRIEF.md
# Reloading Alarm Down Counter

This block is a periodic alarm timer. It holds a seed value, written one byte at a time through a small register port, and a down counter of the same width. The counter steps down by one on each one-second tick. When a tick would take it to zero, the block raises a sticky alarm flag, loads the seed again and carries on. The result is an alarm every `seed` ticks.

An enable input gates the counter. Every rising edge of the enable reloads the counter from the seed. The counter stands still while the enable is low or the seed is zero. Software can read the live count coherently: addressing the least significant byte for read captures the whole count into a holding register, and the counter keeps running while the bytes are fetched. The alarm flag stays set until software clears it.

Top module: `alarm_downcounter`

## Requirements
- R1: After a synchronous reset, `count_o`, `seed_o` and `snap_o` are all zero and `alarm_o` is 0.
- R2: A cycle with `seed_wr_i` high writes `seed_wdata_i` into one byte of the seed. `seed_sel_i` picks the byte: 0 is bits 7:0, 1 is bits 15:8 and 2 is bits 23:16. A write with select 3 changes nothing. The seed is visible on `seed_o` from the cycle after the write.
- R3: In a cycle where `enable_i` is high after being low in the previous cycle, `count_o` takes the current seed in the next cycle. This happens even if a tick arrives in the same cycle.
- R4: While `enable_i` is high and the seed is nonzero, a tick with a count of 2 or more lowers `count_o` by exactly one in the next cycle.
- R5: While enabled with a nonzero seed, a tick with a count of 1 or 0 reloads `count_o` from the seed and sets `alarm_o` in the next cycle. With a seed of N, the alarm therefore recurs every N ticks.
- R6: While `enable_i` is low or the seed is zero, ticks leave `count_o` unchanged and do not set `alarm_o`.
- R7: Writing the seed does not change `count_o`. The new seed is used from the next reload onward.
- R8: `alarm_o` stays set until a cycle with `alarm_clr_i` high clears it. A terminal tick in the same cycle as a clear leaves it set.
- R9: A cycle with `snap_req_i` high and `snap_sel_i` equal to 0 copies the pre-edge `count_o` into `snap_o` in the next cycle. A request with any other select leaves `snap_o` unchanged, and the counter keeps running either way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | One-cycle pulse per second |
| enable_i | input | 1 | Counter enable; a rising edge reloads the counter |
| seed_wr_i | input | 1 | Seed byte write strobe |
| seed_sel_i | input | 2 | Seed byte select, 0 = least significant |
| seed_wdata_i | input | 8 | Seed byte write data |
| snap_req_i | input | 1 | Read-access strobe |
| snap_sel_i | input | 2 | Byte addressed by the read; 0 triggers a capture |
| alarm_clr_i | input | 1 | Clears the alarm flag |
| alarm_o | output | 1 | Sticky alarm flag |
| count_o | output | 24 | Live counter value |
| seed_o | output | 24 | Current seed |
| snap_o | output | 24 | Captured count for reads |

## Verification
The bench aims at the edges of the reload logic.

- **Tick during an enable rise.** A tick arrives in the same cycle as the enable's rising edge. A design that decremented there would show seed minus one instead of the seed.
- **Terminal count reached from zero.** The counter sits at zero after being loaded from a zero seed, and then a nonzero seed is written. A design that wrapped only from one would stall there forever.
- **Clear against terminal tick.** An alarm clear lands in the same cycle as a terminal tick. A design that gave the clear priority would lose an alarm.
- **Byte mapping and snapshots.** The seed byte order, the ignored fourth select, the unchanged count after a seed rewrite, and a snapshot held through later ticks and non-zero-select reads are each checked at the ports. A wrong byte mapping or a capture on every read would show up directly.

// File: rtl/alarm_cnt_pkg.sv
package alarm_cnt_pkg;

    localparam int CNT_W  = 24;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_DEC  = 2'd2,
        ACT_WRAP = 2'd3
    } cnt_act_e;

    typedef struct packed {
        logic rise;
        logic active;
        logic tick;
        logic at_end;
    } cnt_ctl_t;

    function automatic cnt_act_e pick_action(input cnt_ctl_t c);
        if (c.rise)
            return ACT_LOAD;
        else if (c.active && c.tick && c.at_end)
            return ACT_WRAP;
        else if (c.active && c.tick)
            return ACT_DEC;
        else
            return ACT_HOLD;
    endfunction

    function automatic int byte_count(input int width);
        return (width + BYTE_W - 1) / BYTE_W;
    endfunction

endpackage

// File: rtl/seed_store.sv
module seed_store #(
    parameter int CNT_W = alarm_cnt_pkg::CNT_W,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [7:0]       wdata_i,
    output logic [CNT_W-1:0] seed_o
);
    import alarm_cnt_pkg::*;

    localparam int NBYTES = byte_count(CNT_W);
    localparam int PAD_W  = NBYTES * BYTE_W;

    logic [PAD_W-1:0] seed_q;

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                seed_q[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_i && sel_i == SEL_W'(b))
                seed_q[b*BYTE_W +: BYTE_W] <= wdata_i;
        end
    end

    assign seed_o = seed_q[CNT_W-1:0];

    // R2: without a write strobe the seed holds
    a_r2_seed_holds: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(seed_o));

endmodule

// File: rtl/count_core.sv
module count_core #(
    parameter int CNT_W = alarm_cnt_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic [CNT_W-1:0] seed_i,
    output logic [CNT_W-1:0] count_o,
    output logic             terminal_o
);
    import alarm_cnt_pkg::*;

    logic             en_q;
    logic [CNT_W-1:0] cnt_q;
    cnt_ctl_t         ctl;
    cnt_act_e         act;

    always_comb begin
        ctl.rise   = enable_i & ~en_q;
        ctl.active = enable_i & (seed_i != '0);
        ctl.tick   = tick_i;
        ctl.at_end = (cnt_q <= CNT_W'(1));
        act        = pick_action(ctl);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            cnt_q <= '0;
        end else begin
            en_q <= enable_i;
            unique case (act)
                ACT_LOAD: cnt_q <= seed_i;
                ACT_WRAP: cnt_q <= seed_i;
                ACT_DEC:  cnt_q <= cnt_q - CNT_W'(1);
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    assign count_o    = cnt_q;
    assign terminal_o = (act == ACT_WRAP);

    // R3: an enable rising edge loads the seed
    a_r3_rise_loads: assert property (@(posedge clk) disable iff (rst)
        (enable_i && !en_q) |=> count_o == $past(seed_i));

    // R4: an ordinary tick steps down by one
    a_r4_step_down: assert property (@(posedge clk) disable iff (rst)
        (en_q && enable_i && tick_i && seed_i != '0 && count_o > CNT_W'(1))
        |=> count_o == $past(count_o) - CNT_W'(1));

    // R6: with the enable held low the count is frozen
    a_r6_frozen: assert property (@(posedge clk) disable iff (rst)
        (!enable_i) |=> $stable(count_o));

    // R6: a zero seed never produces a terminal count
    a_r6_zero_seed: assert property (@(posedge clk) disable iff (rst)
        (seed_i == '0) |-> !terminal_o);

endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= 1'b0;
        else if (set_i)
            flag_q <= 1'b1;
        else if (clr_i)
            flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R5/R8: a terminal count always leaves the flag set
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R8: without a clear the flag never falls
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

endmodule

// File: rtl/snap_latch.sv
module snap_latch #(
    parameter int CNT_W = alarm_cnt_pkg::CNT_W,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [CNT_W-1:0] count_i,
    output logic [CNT_W-1:0] snap_o
);
    logic             take;
    logic [CNT_W-1:0] snap_q;

    assign take = req_i && (sel_i == '0);

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (take)
            snap_q <= count_i;
    end

    assign snap_o = snap_q;

    // R9: a capture holds the pre-edge count
    a_r9_capture: assert property (@(posedge clk) disable iff (rst)
        take |=> snap_o == $past(count_i));

    // R9: other accesses leave the snapshot alone
    a_r9_hold: assert property (@(posedge clk) disable iff (rst)
        !take |=> $stable(snap_o));

endmodule

// File: rtl/alarm_downcounter.sv
module alarm_downcounter #(
    parameter int CNT_W = alarm_cnt_pkg::CNT_W,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             enable_i,
    input  logic             seed_wr_i,
    input  logic [SEL_W-1:0] seed_sel_i,
    input  logic [7:0]       seed_wdata_i,
    input  logic             snap_req_i,
    input  logic [SEL_W-1:0] snap_sel_i,
    input  logic             alarm_clr_i,
    output logic             alarm_o,
    output logic [CNT_W-1:0] count_o,
    output logic [CNT_W-1:0] seed_o,
    output logic [CNT_W-1:0] snap_o
);
    logic [CNT_W-1:0] seed_w;
    logic [CNT_W-1:0] count_w;
    logic             terminal_w;

    seed_store #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_seed (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (seed_wr_i),
        .sel_i   (seed_sel_i),
        .wdata_i (seed_wdata_i),
        .seed_o  (seed_w)
    );

    count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick_i     (tick_i),
        .enable_i   (enable_i),
        .seed_i     (seed_w),
        .count_o    (count_w),
        .terminal_o (terminal_w)
    );

    alarm_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (terminal_w),
        .clr_i  (alarm_clr_i),
        .flag_o (alarm_o)
    );

    snap_latch #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_snap (
        .clk     (clk),
        .rst     (rst),
        .req_i   (snap_req_i),
        .sel_i   (snap_sel_i),
        .count_i (count_w),
        .snap_o  (snap_o)
    );

    assign count_o = count_w;
    assign seed_o  = seed_w;

    // R7: a seed write alone never moves the count
    a_r7_write_no_effect: assert property (@(posedge clk) disable iff (rst)
        (seed_wr_i && !tick_i && !enable_i) |=> $stable(count_o));

endmodule

// File: tb/alarm_downcounter_bench.sv
module alarm_downcounter_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_i = 1'b0;
    logic        enable_i = 1'b0;
    logic        seed_wr_i = 1'b0;
    logic [1:0]  seed_sel_i = '0;
    logic [7:0]  seed_wdata_i = '0;
    logic        snap_req_i = 1'b0;
    logic [1:0]  snap_sel_i = '0;
    logic        alarm_clr_i = 1'b0;
    logic        alarm_o;
    logic [23:0] count_o;
    logic [23:0] seed_o;
    logic [23:0] snap_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    alarm_downcounter u_alarm_downcounter (
        .clk          (clk),
        .rst          (rst),
        .tick_i       (tick_i),
        .enable_i     (enable_i),
        .seed_wr_i    (seed_wr_i),
        .seed_sel_i   (seed_sel_i),
        .seed_wdata_i (seed_wdata_i),
        .snap_req_i   (snap_req_i),
        .snap_sel_i   (snap_sel_i),
        .alarm_clr_i  (alarm_clr_i),
        .alarm_o      (alarm_o),
        .count_o      (count_o),
        .seed_o       (seed_o),
        .snap_o       (snap_o)
    );

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive strobes after a falling edge, one rising edge, release after the next falling edge
    task automatic step();
        @(negedge clk);
        tick_i      = 1'b0;
        seed_wr_i   = 1'b0;
        snap_req_i  = 1'b0;
        alarm_clr_i = 1'b0;
    endtask

    task automatic write_seed(input logic [1:0] sel, input logic [7:0] val);
        seed_wr_i = 1'b1; seed_sel_i = sel; seed_wdata_i = val;
        step();
    endtask

    task automatic tick();
        tick_i = 1'b1;
        step();
    endtask

    task automatic t_reset();
        check("R1 count", count_o, 24'd0);
        check("R1 seed", seed_o, 24'd0);
        check("R1 snap", snap_o, 24'd0);
        check("R1 alarm", {23'd0, alarm_o}, 24'd0);
    endtask

    task automatic t_seed_bytes();
        write_seed(2'd0, 8'h11);
        write_seed(2'd1, 8'h22);
        write_seed(2'd2, 8'h33);
        check("R2 byte order", seed_o, 24'h332211);
        write_seed(2'd3, 8'hFF);
        check("R2 select 3 ignored", seed_o, 24'h332211);
        write_seed(2'd0, 8'h03);
        write_seed(2'd1, 8'h00);
        write_seed(2'd2, 8'h00);
        check("R2 seed three", seed_o, 24'd3);
    endtask

    task automatic t_rise_and_period();
        enable_i = 1'b1; tick_i = 1'b1;
        step();
        check("R3 rise beats tick", count_o, 24'd3);
        tick();
        check("R4 first step", count_o, 24'd2);
        tick();
        check("R4 second step", count_o, 24'd1);
        check("R5 no alarm yet", {23'd0, alarm_o}, 24'd0);
        tick();
        check("R5 wrap reload", count_o, 24'd3);
        check("R5 alarm set", {23'd0, alarm_o}, 24'd1);
    endtask

    task automatic t_alarm_flag();
        step();
        check("R8 sticky", {23'd0, alarm_o}, 24'd1);
        alarm_clr_i = 1'b1;
        step();
        check("R8 cleared", {23'd0, alarm_o}, 24'd0);
        tick(); tick();
        check("R4 reached one", count_o, 24'd1);
        tick_i = 1'b1; alarm_clr_i = 1'b1;
        step();
        check("R8 set wins over clear", {23'd0, alarm_o}, 24'd1);
        check("R5 reload again", count_o, 24'd3);
    endtask

    task automatic t_seed_rewrite();
        write_seed(2'd0, 8'h05);
        check("R7 count untouched", count_o, 24'd3);
        tick(); tick();
        check("R7 old seed still counting", count_o, 24'd1);
        tick();
        check("R7 new seed on reload", count_o, 24'd5);
    endtask

    task automatic t_snapshot();
        snap_req_i = 1'b1; snap_sel_i = 2'd0; tick_i = 1'b1;
        step();
        check("R9 captured pre-edge", snap_o, 24'd5);
        check("R9 count keeps running", count_o, 24'd4);
        tick();
        check("R9 snap held", snap_o, 24'd5);
        snap_req_i = 1'b1; snap_sel_i = 2'd1;
        step();
        check("R9 select 1 no capture", snap_o, 24'd5);
        snap_req_i = 1'b1; snap_sel_i = 2'd0;
        step();
        check("R9 recapture", snap_o, 24'd3);
    endtask

    task automatic t_disabled();
        enable_i = 1'b0;
        step();
        tick(); tick();
        check("R6 enable low holds", count_o, 24'd3);
        write_seed(2'd0, 8'h00);
        check("R6 seed zero", seed_o, 24'd0);
        alarm_clr_i = 1'b1;
        step();
        enable_i = 1'b1;
        step();
        check("R3 loads zero seed", count_o, 24'd0);
        tick(); tick();
        check("R6 zero seed holds", count_o, 24'd0);
        check("R6 no alarm", {23'd0, alarm_o}, 24'd0);
    endtask

    task automatic t_wrap_from_zero();
        write_seed(2'd0, 8'h02);
        check("R7 zero count stays", count_o, 24'd0);
        tick();
        check("R5 wrap from zero", count_o, 24'd2);
        check("R5 alarm from zero", {23'd0, alarm_o}, 24'd1);
        tick();
        check("R4 step", count_o, 24'd1);
        enable_i = 1'b0;
        step();
        enable_i = 1'b1;
        step();
        check("R3 re-rise reloads", count_o, 24'd2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_seed_bytes();
        t_rise_and_period();
        t_alarm_flag();
        t_seed_rewrite();
        t_snapshot();
        t_disabled();
        t_wrap_from_zero();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule